// File: doc/BRIEF.md
# Ternary Routing Channel Switch

This block models one routing cell of a configurable ternary logic array. Twelve vertical routing lines each connect to at most one of fifteen horizontal lines. Fourteen of the horizontal lines come from the seven logic cells of the row, two per cell: the cell's primary output and its auxiliary output. The fifteenth horizontal line carries an external pin.

A 48-bit configuration word, loaded as six bytes, holds one 4-bit selector per vertical line. A selector of zero leaves its vertical line undriven. The block is purely combinational, so any change on the configuration or on a horizontal line reaches the vertical outputs without a clock.

Each trit is carried on two wires with this encoding: 2'b00 is O (neutral), 2'b01 is P (positive) and 2'b10 is N (negative). The switch copies the selected pair unchanged.

Top module: `ternRouteSwitch`

## Requirements
- R1: A vertical line whose 4-bit selector is 0 outputs trit O (2'b00).
- R2: For selector codes 1 to 14, an odd code 2m-1 routes the primary output of logic cell m, and an even code 2m routes the auxiliary output of cell m. Cells are numbered 1 to 7, and cell m occupies bits 2m-1:2m-2 of `cellMain` and of `cellAux`.
- R3: Selector code 15 routes the external pin trit `extPin`.
- R4: The selector for vertical line k (0 to 11) sits in bits 4k+3:4k of `routeCfg`, so the low nibble of byte 0 serves line 0. Vertical line k drives bits 2k+1:2k of `vertOut` and bit k of `vertValid`.
- R5: `vertValid` bit k is 1 exactly when selector k is nonzero.
- R6: Each vertical line takes exactly the trit on its selected horizontal line, independently of the other vertical lines. Several vertical lines may select the same horizontal line, and each of them receives its value.
- R7: The switch is combinational. Outputs settle to the new routing in the same cycle that the configuration or the inputs change, with no clock latency.
- R8: A routed trit passes bit for bit, including the unused code 2'b11, and no other horizontal line affects it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cellMain | input | 14 | Primary output trit of each of the 7 logic cells (cell m at bits 2m-1:2m-2) |
| cellAux | input | 14 | Auxiliary output trit of each of the 7 logic cells |
| extPin | input | 2 | External pin trit, horizontal line 15 |
| routeCfg | input | 48 | Twelve 4-bit selectors, one per vertical line |
| vertOut | output | 24 | Routed trit of each vertical line |
| vertValid | output | 12 | High where a vertical line is connected |

## Verification
The bench builds the block with its default parameters: seven cells, which give fifteen horizontal lines, and twelve vertical lines. With these values every 4-bit selector code names a real line, so codes 0, 1, 14 and 15 and the cell-pair boundaries can all be reached. Random configurations over the full nibble range, combined with random horizontal trits that include the unused code, exercise shared selections and the independence of the vertical lines. Directed patterns fix the all-zero configuration, the all-external configuration, and a walk of every code across every field.

// File: rtl/ternRoutePkg.sv
package ternRoutePkg;
  localparam int CELL_COUNT = 7;
  localparam int HORZ_COUNT = 2 * CELL_COUNT + 1;
  localparam int VERT_COUNT = 12;
  localparam int SEL_W      = $clog2(HORZ_COUNT + 1);
  localparam int TRIT_W     = 2;

  typedef logic [TRIT_W-1:0] trit_t;
  localparam trit_t TRIT_O = 2'b00;
  localparam trit_t TRIT_P = 2'b01;
  localparam trit_t TRIT_N = 2'b10;

  // strobes from decode control to the mux datapath, one per vertical line
  typedef struct packed {
    logic                  link;
    logic [HORZ_COUNT-1:0] pick;
  } lineStrobe_t;
endpackage

// File: rtl/ternRouteCtrl.sv
module ternRouteCtrl
  import ternRoutePkg::*;
#(
  parameter int NUM_VERT = VERT_COUNT,
  parameter int NUM_HORZ = HORZ_COUNT,
  parameter int CODE_W   = SEL_W,
  localparam int CFG_W   = NUM_VERT * CODE_W
) (
  input  logic [CFG_W-1:0] routeCfg,
  output lineStrobe_t      strb [NUM_VERT]
);
  logic [CODE_W-1:0] code [NUM_VERT];

  for (genvar v = 0; v < NUM_VERT; v++) begin : g_field
    assign code[v] = routeCfg[v*CODE_W +: CODE_W];

    always_comb begin
      strb[v].link = 1'b0;
      strb[v].pick = '0;
      for (int h = 0; h < NUM_HORZ; h++) begin
        if (code[v] == CODE_W'(h + 1)) begin
          strb[v].pick[h] = 1'b1;
          strb[v].link    = 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int v = 0; v < NUM_VERT; v++) begin
      // R6
      one_pick_chk: assert ($onehot0(strb[v].pick));
      // R5
      zero_code_chk: assert ((code[v] != '0) || !strb[v].link);
    end
  end
endmodule

// File: rtl/ternRouteDatapath.sv
module ternRouteDatapath
  import ternRoutePkg::*;
#(
  parameter int NUM_VERT = VERT_COUNT,
  parameter int NUM_HORZ = HORZ_COUNT
) (
  input  trit_t       horz     [NUM_HORZ],
  input  lineStrobe_t strb     [NUM_VERT],
  output trit_t       vertTrit [NUM_VERT],
  output logic        vertLink [NUM_VERT]
);
  for (genvar v = 0; v < NUM_VERT; v++) begin : g_mux
    always_comb begin
      vertTrit[v] = TRIT_O;
      for (int h = 0; h < NUM_HORZ; h++) begin
        vertTrit[v] = vertTrit[v] | ({TRIT_W{strb[v].pick[h]}} & horz[h]);
      end
      vertLink[v] = strb[v].link;
    end
  end

  always_comb begin
    for (int v = 0; v < NUM_VERT; v++) begin
      // R1
      idle_line_chk: assert (strb[v].link || (vertTrit[v] == TRIT_O));
      for (int h = 0; h < NUM_HORZ; h++) begin
        if (strb[v].pick[h]) begin
          // R8
          mux_match_chk: assert (vertTrit[v] == horz[h]);
        end
      end
    end
  end
endmodule

// File: rtl/ternRouteSwitch.sv
module ternRouteSwitch
  import ternRoutePkg::*;
#(
  parameter int NUM_CELLS = CELL_COUNT,
  parameter int NUM_VERT  = VERT_COUNT,
  localparam int NUM_HORZ = 2 * NUM_CELLS + 1,
  localparam int CODE_W   = $clog2(NUM_HORZ + 1),
  localparam int CFG_W    = NUM_VERT * CODE_W
) (
  input  logic [NUM_CELLS*TRIT_W-1:0] cellMain,
  input  logic [NUM_CELLS*TRIT_W-1:0] cellAux,
  input  logic [TRIT_W-1:0]           extPin,
  input  logic [CFG_W-1:0]            routeCfg,
  output logic [NUM_VERT*TRIT_W-1:0]  vertOut,
  output logic [NUM_VERT-1:0]         vertValid
);
  trit_t       horz     [NUM_HORZ];
  lineStrobe_t strb     [NUM_VERT];
  trit_t       vertTrit [NUM_VERT];
  logic        vertLink [NUM_VERT];

  // line 2m-1 is cell m primary, line 2m its auxiliary, last line the pin
  for (genvar m = 0; m < NUM_CELLS; m++) begin : g_cell
    assign horz[2*m]     = cellMain[m*TRIT_W +: TRIT_W];
    assign horz[2*m + 1] = cellAux[m*TRIT_W +: TRIT_W];
  end
  assign horz[NUM_HORZ-1] = extPin;

  ternRouteCtrl #(
    .NUM_VERT (NUM_VERT),
    .NUM_HORZ (NUM_HORZ),
    .CODE_W   (CODE_W)
  ) ctrl (
    .routeCfg (routeCfg),
    .strb     (strb)
  );

  ternRouteDatapath #(
    .NUM_VERT (NUM_VERT),
    .NUM_HORZ (NUM_HORZ)
  ) dp (
    .horz     (horz),
    .strb     (strb),
    .vertTrit (vertTrit),
    .vertLink (vertLink)
  );

  for (genvar v = 0; v < NUM_VERT; v++) begin : g_pack
    assign vertOut[v*TRIT_W +: TRIT_W] = vertTrit[v];
    assign vertValid[v]                = vertLink[v];
  end

  always_comb begin
    for (int v = 0; v < NUM_VERT; v++) begin
      if (routeCfg[v*CODE_W +: CODE_W] == CODE_W'(NUM_HORZ)) begin
        // R3
        ext_pin_chk: assert (vertOut[v*TRIT_W +: TRIT_W] == extPin && vertValid[v]);
      end
    end
  end
endmodule

// File: tb/ternRouteSwitch_test.sv
module ternRouteSwitch_test;
  logic        clk = 1'b0;
  logic [13:0] cellMain = '0;
  logic [13:0] cellAux  = '0;
  logic [1:0]  extPin   = '0;
  logic [47:0] routeCfg = '0;
  logic [23:0] vertOut;
  logic [11:0] vertValid;
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ternRouteSwitch uut (
    .cellMain  (cellMain),
    .cellAux   (cellAux),
    .extPin    (extPin),
    .routeCfg  (routeCfg),
    .vertOut   (vertOut),
    .vertValid (vertValid)
  );

  function automatic logic [1:0] expTrit(input logic [47:0] cfg, input int v,
                                         input logic [13:0] mn, input logic [13:0] ax,
                                         input logic [1:0] ep);
    int code = int'(cfg[4*v +: 4]);
    int m;
    if (code == 0) return 2'b00;
    if (code == 15) return ep;
    m = (code - 1) / 2;
    if (code % 2 == 1) return mn[2*m +: 2];
    return ax[2*m +: 2];
  endfunction

  task automatic checkAll(input string tag);
    @(negedge clk);
    for (int v = 0; v < 12; v++) begin
      logic [1:0] e = expTrit(routeCfg, v, cellMain, cellAux, extPin);
      logic ev = (routeCfg[4*v +: 4] != 4'd0);
      checks++;
      if (vertOut[2*v +: 2] !== e) begin
        errors++;
        $display("FAIL %s line %0d trit: actual %b expected %b", tag, v, vertOut[2*v +: 2], e);
      end
      checks++;
      if (vertValid[v] !== ev) begin
        errors++;
        $display("FAIL R5 %s line %0d valid: actual %b expected %b", tag, v, vertValid[v], ev);
      end
    end
  endtask

  task automatic apply(input logic [47:0] c, input logic [13:0] mn,
                       input logic [13:0] ax, input logic [1:0] ep);
    @(posedge clk);
    routeCfg = c; cellMain = mn; cellAux = ax; extPin = ep;
  endtask

  initial begin
    logic [47:0] c;
    void'($urandom(32'h5eed_7e1a));
    // R1 all-zero configuration: everything idle at O
    apply('0, 14'h3fff, 14'h2aaa, 2'b01);
    checkAll("R1");
    // R3 every line on the external pin, each pin value
    for (int p = 0; p < 4; p++) begin
      apply({12{4'hf}}, 14'h1555, 14'h2aaa, 2'(p));
      checkAll("R3");
    end
    // R2 R4 walk every code through every field
    for (int code = 0; code < 16; code++) begin
      for (int v = 0; v < 12; v++) begin
        c = '0;
        c[4*v +: 4] = 4'(code);
        apply(c, 14'(($urandom)), 14'($urandom), 2'($urandom));
        checkAll("R2_R4");
      end
    end
    // R6 all lines share one horizontal line
    apply({12{4'h5}}, 14'b00_00_10_00_00_00_00, 14'h0, 2'b10);
    checkAll("R6");
    // R7 inputs change under a fixed configuration, seen in the same cycle
    c = 48'hfedc_ba98_7654;
    for (int i = 0; i < 20; i++) begin
      apply(c, 14'($urandom), 14'($urandom), 2'($urandom));
      checkAll("R7");
    end
    // R8 random routing with raw codes including 2'b11
    for (int i = 0; i < 400; i++) begin
      apply({$urandom, 16'($urandom)}, 14'($urandom), 14'($urandom), 2'($urandom));
      checkAll("R8");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule